// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block is a hardware master for a three-wire serial EEPROM that stores 16-bit words. A host asks for a burst by giving a first word address, a word count and a byte-exchange flag. For each word the block raises chip select and a companion select line. It then clocks out an 11-bit read command, which is the read opcode merged with the word address, and clocks in sixteen data bits. After the last bit it drops every port line to zero.

Each word it collects is offered on a valid/ready stream. Words are exchanged byte-for-byte on the way out when the flag was set. The sequence waits while the stream is stalled, so no serial clocking takes place until the pending word is taken. All serial phase lengths come from a prescaler that counts system clocks. The setup, clock-high and hold lengths are separate parameters.

Top module: `ee_word_reader`

## Requirements
- R1: After reset, `busy`, `word_valid`, `ee_cs`, `ee_sel`, `ee_sk` and `ee_di` are all low.
- R2: A request with `req_valid` high and a non-zero `req_count` is taken while idle. `busy` is high from the next cycle until the cycle after the last word is accepted. A request made while `busy` is high is ignored.
- R3: Each word access shifts out 11 command bits MSB first. Bits 10:9 are 0, bits 8:6 are the read code 1,1,0, and bits 5:0 are the word address.
- R4: `ee_di` changes only while `ee_sk` is low. Every `ee_sk` high pulse lasts exactly HIGH_CYC system clocks.
- R5: `ee_cs` and `ee_sel` are high together for the whole word access, and `ee_sk` never pulses while they are low. Each access gives exactly 27 clock pulses, 11 for the command and 16 for the data.
- R6: The 16 data bits are sampled MSB first near the end of each clock-high phase. The returned word equals the stored word.
- R7: A burst reads `req_count` consecutive addresses from `req_addr`, wrapping modulo 2^ADDR_W.
- R8: With `req_swap` set, bits 15:8 and 7:0 of each returned word are exchanged. With it clear, the word is returned unchanged.
- R9: While `word_valid` is high and `word_ready` is low, `word_data` stays stable and all serial lines stay low.
- R10: A request with `req_count` equal to zero is ignored. `busy` stays low and no access starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start request strobe |
| req_addr | input | ADDR_W | First word address |
| req_count | input | CNT_W | Number of words to read |
| req_swap | input | 1 | Exchange bytes of each word |
| busy | output | 1 | Burst in progress |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sel | output | 1 | EEPROM access-mode select |
| ee_sk | output | 1 | Serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| word_valid | output | 1 | Returned word available |
| word_ready | input | 1 | Downstream takes the word |
| word_data | output | 16 | Returned word |

## Verification
A wrong phase or bit counter shows up within one word access. The responder sees a pulse count other than 27, or a command without the 1,1,0 code in place, and it then returns all ones, so the data compare fails on the first word. A bad address register or word counter shows up as the wrong stored pattern, or as an early or late fall of `busy`, within the burst. A faulty stall path is seen as data that moves, or as serial activity, during a stalled cycle.

// File: rtl/ee_rd_pkg.sv
// Shared types for the serial EEPROM word reader.
// Assumes nothing beyond a synthesizable enum encoding.
package ee_rd_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_SEL,
        PH_CMD_SU,
        PH_CMD_HI,
        PH_CMD_HO,
        PH_GAP,
        PH_DAT_HI,
        PH_DAT_LO,
        PH_END,
        PH_OUT
    } ee_phase_e;

endpackage

// File: rtl/ee_rd_phase_timer.sv
// Phase prescaler: counts system clocks within one serial phase and
// flags the last cycle of that phase. It wraps to zero on the last cycle,
// so back-to-back phases need no extra restart.
// Assumes limit >= 1 and stable for the length of a phase.
module ee_rd_phase_timer #(
    parameter int TMR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [TMR_W-1:0] limit,
    output logic             last
);

    logic [TMR_W-1:0] cnt;

    // Terminal count of the current phase.
    always_comb last = (cnt == (limit - 1'b1));

    // Advance the count, restart at phase end or while held clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || last) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/ee_rd_byte_swap.sv
// Optional byte-lane reversal of a word; pure combinational.
// Assumes WORD_W is a multiple of 8.
module ee_rd_byte_swap #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] din,
    input  logic              en,
    output logic [WORD_W-1:0] dout
);

    localparam int NB = WORD_W / 8;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        // Pick either the same lane or the mirrored lane.
        assign dout[b*8 +: 8] = en ? din[(NB-1-b)*8 +: 8] : din[b*8 +: 8];
    end

endmodule

// File: rtl/ee_word_reader.sv
// Serial EEPROM burst reader. For each word it selects the device, shifts
// out the read code merged with the address (MSB first), clocks in 16 data
// bits, clears the port and offers the word on a valid/ready stream.
// Assumes CMD_W >= ADDR_W + 3 and every phase length >= 1 clock.
module ee_word_reader
    import ee_rd_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int CNT_W     = 8,
    parameter int CMD_W     = 11,
    parameter int SETUP_CYC = 2,
    parameter int HIGH_CYC  = 3,
    parameter int HOLD_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_count,
    input  logic              req_swap,
    output logic              busy,
    output logic              ee_cs,
    output logic              ee_sel,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do,
    output logic              word_valid,
    input  logic              word_ready,
    output logic [15:0]       word_data
);

    localparam int WORD_W = 16;
    localparam int TMR_W  = $clog2(SETUP_CYC + HIGH_CYC + HOLD_CYC + 1);
    localparam int BC_W   = $clog2((CMD_W > WORD_W) ? CMD_W : WORD_W);
    localparam logic [CMD_W-1:0] RD_CODE = {{(CMD_W-3){1'b0}}, 3'b110} << ADDR_W;

    ee_phase_e          phase;
    logic [CMD_W-1:0]   cmd_sr;
    logic [WORD_W-1:0]  rx_sr;
    logic [BC_W-1:0]    bit_cnt;
    logic [ADDR_W-1:0]  cur_addr;
    logic [CNT_W-1:0]   words_left;
    logic               swap_q;
    logic [TMR_W-1:0]   ph_len;
    logic               ph_last;
    logic               tmr_clr;
    logic               start_ok;

    // Phase length selected by the current phase.
    always_comb begin
        unique case (phase)
            PH_CMD_HI, PH_DAT_HI:         ph_len = TMR_W'(HIGH_CYC);
            PH_CMD_HO, PH_DAT_LO, PH_END: ph_len = TMR_W'(HOLD_CYC);
            default:                      ph_len = TMR_W'(SETUP_CYC);
        endcase
    end

    // Timer held at zero while no serial phase is running.
    always_comb tmr_clr = (phase == PH_IDLE) || (phase == PH_OUT);

    ee_rd_phase_timer #(.TMR_W(TMR_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .limit (ph_len),
        .last  (ph_last)
    );

    // Request acceptance only when idle and with a non-zero count.
    always_comb start_ok = (phase == PH_IDLE) && req_valid && (req_count != '0);

    // Main sequencer: phases, counters and shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            cmd_sr     <= '0;
            rx_sr      <= '0;
            bit_cnt    <= '0;
            cur_addr   <= '0;
            words_left <= '0;
            swap_q     <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start_ok) begin
                    cur_addr   <= req_addr;
                    words_left <= req_count;
                    swap_q     <= req_swap;
                    phase      <= PH_SEL;
                end
                PH_SEL: if (ph_last) begin
                    cmd_sr  <= RD_CODE | CMD_W'(cur_addr);
                    bit_cnt <= BC_W'(CMD_W - 1);
                    phase   <= PH_CMD_SU;
                end
                PH_CMD_SU: if (ph_last) phase <= PH_CMD_HI;
                PH_CMD_HI: if (ph_last) phase <= PH_CMD_HO;
                PH_CMD_HO: if (ph_last) begin
                    if (bit_cnt == '0) begin
                        phase <= PH_GAP;
                    end else begin
                        cmd_sr  <= cmd_sr << 1;
                        bit_cnt <= bit_cnt - 1'b1;
                        phase   <= PH_CMD_SU;
                    end
                end
                PH_GAP: if (ph_last) begin
                    bit_cnt <= BC_W'(WORD_W - 1);
                    phase   <= PH_DAT_HI;
                end
                PH_DAT_HI: if (ph_last) begin
                    rx_sr <= {rx_sr[WORD_W-2:0], ee_do};
                    phase <= PH_DAT_LO;
                end
                PH_DAT_LO: if (ph_last) begin
                    if (bit_cnt == '0) begin
                        phase <= PH_END;
                    end else begin
                        bit_cnt <= bit_cnt - 1'b1;
                        phase   <= PH_DAT_HI;
                    end
                end
                PH_END: if (ph_last) phase <= PH_OUT;
                PH_OUT: if (word_ready) begin
                    if (words_left == CNT_W'(1)) begin
                        phase <= PH_IDLE;
                    end else begin
                        words_left <= words_left - 1'b1;
                        cur_addr   <= cur_addr + 1'b1;
                        phase      <= PH_SEL;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Serial port decode from the registered phase.
    always_comb begin
        ee_cs  = (phase == PH_SEL)    || (phase == PH_CMD_SU) || (phase == PH_CMD_HI) ||
                 (phase == PH_CMD_HO) || (phase == PH_GAP)    || (phase == PH_DAT_HI) ||
                 (phase == PH_DAT_LO);
        ee_sel = ee_cs;
        ee_sk  = (phase == PH_CMD_HI) || (phase == PH_DAT_HI);
        ee_di  = ((phase == PH_CMD_SU) || (phase == PH_CMD_HI) || (phase == PH_CMD_HO))
                 && cmd_sr[CMD_W-1];
    end

    // Stream side and burst status.
    always_comb begin
        word_valid = (phase == PH_OUT);
        busy       = (phase != PH_IDLE);
    end

    ee_rd_byte_swap #(.WORD_W(WORD_W)) u_swap (
        .din  (rx_sr),
        .en   (swap_q),
        .dout (word_data)
    );

endmodule

// File: rtl/ee_word_reader_chk.sv
// Protocol checker for ee_word_reader, attached by bind. Observes ports
// only; keeps one counter for the clock-high width.
module ee_word_reader_chk #(
    parameter int ADDR_W    = 6,
    parameter int CNT_W     = 8,
    parameter int HIGH_CYC  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [CNT_W-1:0]  req_count,
    input logic              busy,
    input logic              ee_cs,
    input logic              ee_sel,
    input logic              ee_sk,
    input logic              ee_di,
    input logic              word_valid,
    input logic              word_ready,
    input logic [15:0]       word_data
);

    logic [7:0] hi_len;

    // Length of the current clock-high run, in system clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_len <= '0;
        else if (ee_sk) hi_len <= hi_len + 1'b1;
        else            hi_len <= '0;
    end

    AST_QUIET_IN_RESET: assert property (@(posedge clk) !rst_n |=> !busy && !ee_cs && !ee_sk && !word_valid); // R1
    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n) !busy && req_valid && (req_count != '0) |=> busy); // R2
    AST_IDLE_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !busy && req_valid && (req_count == '0) |=> !busy); // R10
    AST_DI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n) ee_sk && $past(ee_sk) |-> $stable(ee_di)); // R4
    AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(ee_sk) |-> hi_len == 8'(HIGH_CYC)); // R4
    AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n) ee_sk |-> ee_cs && ee_sel); // R5
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) word_valid && !word_ready |=> word_valid && $stable(word_data)); // R9
    AST_PORT_LOW_OUT: assert property (@(posedge clk) disable iff (!rst_n) word_valid |-> !ee_cs && !ee_sk && !ee_di && busy); // R9

endmodule

bind ee_word_reader ee_word_reader_chk #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .HIGH_CYC (HIGH_CYC)
) u_chk (.*);

// File: tb/ee_word_reader_bench.sv
// Bench: behavioural EEPROM responder plus seeded random and directed bursts.
module ee_word_reader_bench;

    localparam int ADDR_W = 6;
    localparam int CNT_W  = 8;
    localparam int SU     = 2;
    localparam int HI     = 3;
    localparam int HO     = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [CNT_W-1:0] req_count = '0;
    logic req_swap = 1'b0;
    logic busy, ee_cs, ee_sel, ee_sk, ee_di, word_valid;
    logic ee_do = 1'b0;
    logic word_ready = 1'b0;
    logic [15:0] word_data;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    ee_word_reader #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CMD_W(11),
        .SETUP_CYC(SU), .HIGH_CYC(HI), .HOLD_CYC(HO)
    ) u_ee_word_reader (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_count(req_count), .req_swap(req_swap), .busy(busy), .ee_cs(ee_cs),
        .ee_sel(ee_sel), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
        .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data)
    );

    function automatic logic [15:0] mem_word(input logic [ADDR_W-1:0] a);
        return (16'(a) * 16'd2749) ^ 16'hC35A;
    endfunction

    function automatic logic [15:0] exp_word(input logic [ADDR_W-1:0] a, input bit sw);
        logic [15:0] w = mem_word(a);
        return sw ? {w[7:0], w[15:8]} : w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural EEPROM responder and port monitor, sampled on falling edges.
    logic prev_cs = 1'b0, prev_sk = 1'b0, prev_di = 1'b0;
    int edges = 0;
    int hi_run = 0;
    logic [10:0] cmd = '0;
    bit cmd_ok = 1'b0;
    logic [ADDR_W-1:0] seen_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ee_sel != ee_cs) chk(1'b0, "R5 sel/cs mismatch", 32'(ee_sel), 32'(ee_cs));
            if (ee_sk && !ee_cs) chk(1'b0, "R5 clock without cs", 32'(ee_sk), 32'd0);
            if (ee_sk && prev_sk && ee_di != prev_di) chk(1'b0, "R4 di moved in high", 32'(ee_di), 32'(prev_di));
            if (ee_cs && !prev_cs) begin
                edges = 0;
                cmd = '0;
                cmd_ok = 1'b0;
            end
            if (ee_sk && !prev_sk && ee_cs) begin
                edges++;
                if (edges <= 11) begin
                    cmd = {cmd[9:0], ee_di};
                    if (edges == 11) begin
                        cmd_ok = (cmd[10:6] == 5'b00110);
                        seen_addr = cmd[ADDR_W-1:0];
                    end
                end else if (edges <= 27) begin
                    ee_do <= cmd_ok ? mem_word(seen_addr)[27-edges] : 1'b1;
                end
            end
            if (!ee_sk && prev_sk) chk(hi_run == HI, "R4 clock-high width", 32'(hi_run), 32'(HI));
            hi_run = ee_sk ? hi_run + 1 : 0;
            if (!ee_cs && prev_cs) begin
                chk(edges == 27, "R5 pulses per access", 32'(edges), 32'd27);
                chk(cmd_ok, "R3 command code", 32'(cmd), 32'h180);
            end
        end
        prev_cs = ee_cs;
        prev_sk = ee_sk;
        prev_di = ee_di;
    end

    task automatic wait_valid(output bit ok);
        int t = 0;
        while (!word_valid && t < 5000) begin
            @(negedge clk);
            t++;
        end
        ok = word_valid;
    endtask

    // One burst: optional request while busy, random stalls, per-word compare.
    task automatic burst(input logic [ADDR_W-1:0] a, input int n, input bit sw, input bit poke);
        bit ok;
        @(negedge clk);
        req_addr = a; req_count = CNT_W'(n); req_swap = sw; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", 32'(busy), 32'd1);
        if (poke) begin
            req_addr = a + 6'd17; req_count = 8'd3; req_swap = ~sw; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            req_swap = sw;
        end
        for (int i = 0; i < n; i++) begin
            logic [15:0] held;
            int stall;
            wait_valid(ok);
            if (!ok) begin
                chk(1'b0, "R6 word never offered", 32'd0, 32'd1);
                return;
            end
            held = word_data;
            stall = $urandom_range(0, 4);
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                chk(word_valid && word_data == held && !ee_cs && !ee_sk, "R9 stall hold",
                    32'(word_data), 32'(held));
            end
            // R6 R7 R8: stored word of address a+i, bytes exchanged if requested
            chk(word_data == exp_word(a + ADDR_W'(i), sw), "R6/R7/R8 word", 32'(word_data),
                32'(exp_word(a + ADDR_W'(i), sw)));
            word_ready = 1'b1;
            @(negedge clk);
            word_ready = 1'b0;
            if (i < n - 1) chk(busy == 1'b1, "R2 busy mid-burst", 32'(busy), 32'd1);
        end
        chk(!busy && !word_valid, "R2 idle after last word", 32'(busy), 32'd0);
    endtask

    initial begin
        int wd = 0;
        while (wd < 150000) begin
            @(posedge clk);
            wd++;
        end
        chk(1'b0, "watchdog expired", 32'(wd), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: quiet port and stream during reset
        chk(!busy && !word_valid && !ee_cs && !ee_sel && !ee_sk && !ee_di, "R1 reset state",
            {busy, word_valid, ee_cs, ee_sel, ee_sk, ee_di}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !ee_cs, "R1 idle after reset", 32'(busy), 32'd0);

        // R10: zero-count request leaves the block idle
        req_addr = 6'd5; req_count = '0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (busy || ee_cs) chk(1'b0, "R10 zero count started", 32'(busy), 32'd0);
        end
        chk(!busy && !ee_cs && !word_valid, "R10 zero count ignored", 32'(busy), 32'd0);

        burst(6'd0, 1, 1'b0, 1'b0);
        burst(6'd62, 4, 1'b0, 1'b0);   // R7 address wrap
        burst(6'd63, 2, 1'b1, 1'b0);   // R8 swap across wrap
        burst(6'd20, 3, 1'b0, 1'b1);   // R2 request while busy ignored
        burst(6'd41, 2, 1'b1, 1'b1);

        for (int r = 0; r < 14; r++) begin
            burst(ADDR_W'($urandom()), $urandom_range(1, 4), 1'($urandom()), 1'($urandom()));
        end

        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule